// File: doc/BRIEF.md
# I2C Arbitration and Status Flag Unit

This unit sits beside the byte engine of an I2C controller. Each cycle it compares the SDA level the local master drives with the level sampled on the wire, and it watches START and STOP detection, the bus-busy state, the mode bits and the master's own START, repeated-START and STOP requests. From these it decides whether arbitration has been lost. It holds the arbitration-lost flag, the slave read/write bit and a single interrupt flag that merges every event the host must service.

The byte engine tells the unit which kind of bit is on the wire (an address or data bit the master transmits, an acknowledge the master drives while receiving, or an acknowledge the master samples after transmitting) and pulses a strobe at the SDA sample point. When arbitration is lost, the unit tells the SCL/SDA driver to release the bus and tells the master to fall back to slave operation, in the same cycle. The host clears flags by writing ones. An interrupt request is raised while the interrupt flag and the interrupt enable are both set.

Top module: `i2c_arb_status`

## Requirements
- R1: With `sda_strobe` high, `bit_phase` = 1 (address/data transmit bit) and `is_master` high, a driven-high SDA (`sda_drv`=1) sampled low (`sda_smp`=0) sets `arb_lost` at the next clock edge. No loss is flagged without the strobe, or when the master drives low.
- R2: The same driven-high/sampled-low mismatch during `bit_phase` = 2 (acknowledge driven by a receiving master) sets `arb_lost`.
- R3: `start_req` while `bus_busy` is high sets `arb_lost`, and so does `rstart_req` while `is_master` is low. A START requested on an idle bus, or a repeated START requested as master, sets nothing.
- R4: `stop_seen` while `is_master` is high and `stop_req` is low sets `arb_lost`. A STOP the master requested, or a STOP seen in slave mode, does not.
- R5: `arb_lost` and `int_flag` clear only when a host write (`host_wr`) carries a 1 in their bit (`host_al_bit`, `host_if_bit`). A written 0 leaves the flag unchanged.
- R6: When a hardware set and a host write-one clear of the same flag arrive in the same cycle, the flag ends up set.
- R7: `int_flag` is set at the next edge by any arbitration loss, by `byte_done`, by `addr_hit`, or by a missing acknowledge (`bit_phase` = 3, strobe, `sda_smp`=1) while `is_master` and `is_tx` are both high. A missing acknowledge seen by a receiving master sets nothing.
- R8: A high-to-low transition of `bus_busy` sets `int_flag` only while `idle_irq_en` is high. A low-to-high transition never sets it.
- R9: `irq` is high exactly when `int_flag` and `irq_en` are both high.
- R10: On `addr_hit`, `slave_rw` loads `rw_bit` (0 = slave receives, 1 = slave transmits) and keeps that value until the next `addr_hit`.
- R11: In the cycle a loss condition is present, `bus_release` is high and `master_keep` is low, without waiting for a clock edge. Both stay in that state while `arb_lost` is set.
- R12: After reset, `arb_lost`, `int_flag`, `slave_rw` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_phase | input | 2 | Kind of bit on the wire: 0 none, 1 address/data transmit, 2 receive acknowledge, 3 transmit acknowledge |
| sda_strobe | input | 1 | One-cycle pulse at the SDA sample point |
| sda_drv | input | 1 | Level the local master drives on SDA (1 = released/high) |
| sda_smp | input | 1 | Level sampled on SDA |
| is_master | input | 1 | Master mode bit |
| is_tx | input | 1 | Transmit direction bit |
| start_req | input | 1 | Pulse: master attempts a START |
| rstart_req | input | 1 | Pulse: repeated START requested |
| stop_req | input | 1 | Level: master has asked for a STOP |
| stop_seen | input | 1 | Pulse: STOP condition detected on the bus |
| bus_busy | input | 1 | Bus-busy state |
| byte_done | input | 1 | Pulse: byte transfer complete |
| addr_hit | input | 1 | Pulse: own slave address matched |
| rw_bit | input | 1 | R/W bit received with the address |
| host_wr | input | 1 | Host write strobe to the status flags |
| host_al_bit | input | 1 | Written value for the arbitration-lost bit |
| host_if_bit | input | 1 | Written value for the interrupt flag bit |
| irq_en | input | 1 | Interrupt enable |
| idle_irq_en | input | 1 | Bus-idle interrupt enable |
| arb_lost | output | 1 | Arbitration-lost flag |
| slave_rw | output | 1 | Captured slave read/write bit |
| int_flag | output | 1 | Combined interrupt flag |
| irq | output | 1 | Interrupt request |
| bus_release | output | 1 | Release SDA and SCL now |
| master_keep | output | 1 | Master mode may be kept this cycle |

## Verification
Every flag (`arb_lost`, `int_flag`, `slave_rw`) changes at the first rising edge after its stimulus: there is one register on the path, and the bus-idle edge is taken from the live `bus_busy` against its copy from the previous cycle. `irq`, `bus_release` and `master_keep` are combinational, so they are due in the same cycle as their inputs. The bench drives inputs on the falling edge. It checks the combinational outputs before the next rising edge and the flags at the falling edge that follows it. Each table row then clears the flags with a write before the next row begins.

// File: rtl/i2c_arb_pkg.sv
// Package: shared types for the I2C arbitration and status flag unit.
// Assumes the byte engine encodes the current bit kind with bit_phase_e.
package i2c_arb_pkg;

    // Kind of bit currently on the wire, as reported by the byte engine
    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_XMIT = 2'd1,
        PH_RACK = 2'd2,
        PH_TACK = 2'd3
    } bit_phase_e;

    // Indices of the individual arbitration-loss causes
    localparam int unsigned CAUSE_XMIT   = 0;
    localparam int unsigned CAUSE_RACK   = 1;
    localparam int unsigned CAUSE_BUSY   = 2;
    localparam int unsigned CAUSE_RSTART = 3;
    localparam int unsigned CAUSE_STOP   = 4;
    localparam int unsigned NUM_CAUSE    = 5;

    // Indices of the interrupt-flag sources
    localparam int unsigned SRC_ARB   = 0;
    localparam int unsigned SRC_BYTE  = 1;
    localparam int unsigned SRC_ADDR  = 2;
    localparam int unsigned SRC_NOACK = 3;
    localparam int unsigned SRC_IDLE  = 4;
    localparam int unsigned NUM_SRC   = 5;

endpackage

// File: rtl/arb_loss_detect.sv
// Module: arb_loss_detect
// Purely combinational. Evaluates each arbitration-loss condition in the
// current cycle and reports them as a cause vector plus an OR of the causes.
// It also reports a missing acknowledge for a transmitting master.
// Assumes sda_strobe is a single-cycle pulse at the SDA sample point and
// that start_req, rstart_req and stop_seen are single-cycle pulses.
module arb_loss_detect
    import i2c_arb_pkg::*;
#(
    parameter int unsigned N_CAUSE = NUM_CAUSE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bit_phase_e          phase,
    input  logic                strobe,
    input  logic                drv,
    input  logic                smp,
    input  logic                master,
    input  logic                tx,
    input  logic                start_req,
    input  logic                rstart_req,
    input  logic                stop_req,
    input  logic                stop_seen,
    input  logic                busy,
    output logic [N_CAUSE-1:0]  cause,
    output logic                loss,
    output logic                noack
);

    logic drive_clash;

    // Wire contradicts a released (high) SDA at the sample point
    always_comb drive_clash = strobe && master && drv && !smp;

    // Collect every loss cause in its own slot
    always_comb begin
        cause               = '0;
        cause[CAUSE_XMIT]   = drive_clash && (phase == PH_XMIT);
        cause[CAUSE_RACK]   = drive_clash && (phase == PH_RACK);
        cause[CAUSE_BUSY]   = start_req && busy;
        cause[CAUSE_RSTART] = rstart_req && !master;
        cause[CAUSE_STOP]   = stop_seen && master && !stop_req;
    end

    // Any cause means arbitration is lost this cycle
    always_comb loss = |cause;

    // Missing acknowledge after a byte sent by this master
    always_comb noack = strobe && (phase == PH_TACK) && smp && master && tx;

    // R3: a START attempt on a busy bus is always reported as a loss
    p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && busy) |-> loss);

    // R4: a STOP the master requested is never a loss by itself
    p_req_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && stop_req && !start_req && !rstart_req && !strobe) |-> !loss);

    // R1: a low drive by the master can never clash
    p_low_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv && !start_req && !rstart_req && !stop_seen) |-> !loss);

endmodule

// File: rtl/bus_idle_edge.sv
// Module: bus_idle_edge
// Registers bus_busy and flags the cycle in which it drops from high to low.
// Assumes bus_busy is already synchronous to clk. The stored copy resets low,
// so no edge is reported on the first cycle after reset.
module bus_idle_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic went_idle
);

    logic busy_q;

    // Keep last cycle's bus-busy level
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Falling edge of bus-busy
    always_comb went_idle = busy_q && !busy;

    // R8: an idle edge is only ever seen with the bus now free
    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        went_idle |-> !busy);

    // R8: a rising bus-busy is never treated as an idle edge
    p_rise_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !went_idle);

endmodule

// File: rtl/status_flags.sv
// Module: status_flags
// Holds the arbitration-lost flag, the combined interrupt flag and the slave
// read/write bit. Hardware sets take priority over host write-one clears
// in the same cycle. Assumes the set inputs are already qualified.
module status_flags
    import i2c_arb_pkg::*;
#(
    parameter int unsigned N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loss,
    input  logic [N_SRC-1:0] sources,
    input  logic             addr_hit,
    input  logic             rw_bit,
    input  logic             host_wr,
    input  logic             host_al_bit,
    input  logic             host_if_bit,
    output logic             arb_lost,
    output logic             int_flag,
    output logic             slave_rw
);

    logic clr_al;
    logic clr_if;
    logic any_src;

    // Decode the host's write-one-to-clear strobes
    always_comb begin
        clr_al = host_wr && host_al_bit;
        clr_if = host_wr && host_if_bit;
    end

    // Merge all interrupt sources
    always_comb any_src = |sources;

    // Arbitration-lost flag: set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)      arb_lost <= 1'b0;
        else if (loss)   arb_lost <= 1'b1;
        else if (clr_al) arb_lost <= 1'b0;
    end

    // Interrupt flag: set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)       int_flag <= 1'b0;
        else if (any_src) int_flag <= 1'b1;
        else if (clr_if)  int_flag <= 1'b0;
    end

    // Slave direction bit captured on an address match
    always_ff @(posedge clk) begin
        if (!rst_n)        slave_rw <= 1'b0;
        else if (addr_hit) slave_rw <= rw_bit;
    end

    // R1: a detected loss is visible in the flag one edge later
    p_loss_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        loss |=> arb_lost);

    // R5: without a written one the lost flag stays set
    p_al_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !(host_wr && host_al_bit)) |=> arb_lost);

    // R5: without a written one the interrupt flag stays set
    p_if_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flag && !(host_wr && host_if_bit)) |=> int_flag);

    // R6: a set in the same cycle as a clear leaves the flag set
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (loss && host_wr && host_al_bit) |=> arb_lost);

    // R7: every rise of the lost flag comes with the interrupt flag
    p_al_raises_if_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> int_flag);

    // R10: an address match loads the received direction bit
    p_rw_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |=> (slave_rw == $past(rw_bit)));

    // R10: the direction bit holds between address matches
    p_rw_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |=> $stable(slave_rw));

endmodule

// File: rtl/i2c_arb_status.sv
// Module: i2c_arb_status (top)
// Arbitration-loss detection, status flags and interrupt gating for an I2C
// controller. Line release and the master drop-out follow a loss in the same
// cycle. Flags update on the next edge. Assumes all inputs are synchronous
// to clk and that the event inputs are single-cycle pulses.
module i2c_arb_status
    import i2c_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bit_phase,
    input  logic       sda_strobe,
    input  logic       sda_drv,
    input  logic       sda_smp,
    input  logic       is_master,
    input  logic       is_tx,
    input  logic       start_req,
    input  logic       rstart_req,
    input  logic       stop_req,
    input  logic       stop_seen,
    input  logic       bus_busy,
    input  logic       byte_done,
    input  logic       addr_hit,
    input  logic       rw_bit,
    input  logic       host_wr,
    input  logic       host_al_bit,
    input  logic       host_if_bit,
    input  logic       irq_en,
    input  logic       idle_irq_en,
    output logic       arb_lost,
    output logic       slave_rw,
    output logic       int_flag,
    output logic       irq,
    output logic       bus_release,
    output logic       master_keep
);

    logic [NUM_CAUSE-1:0] cause;
    logic [NUM_SRC-1:0]   sources;
    logic                 loss;
    logic                 noack;
    logic                 went_idle;
    bit_phase_e           phase;

    // Present the raw phase code as the shared enum
    always_comb phase = bit_phase_e'(bit_phase);

    arb_loss_detect #(.N_CAUSE(NUM_CAUSE)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .strobe     (sda_strobe),
        .drv        (sda_drv),
        .smp        (sda_smp),
        .master     (is_master),
        .tx         (is_tx),
        .start_req  (start_req),
        .rstart_req (rstart_req),
        .stop_req   (stop_req),
        .stop_seen  (stop_seen),
        .busy       (bus_busy),
        .cause      (cause),
        .loss       (loss),
        .noack      (noack)
    );

    bus_idle_edge u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (bus_busy),
        .went_idle (went_idle)
    );

    // Route each interrupt source into its slot
    always_comb begin
        sources           = '0;
        sources[SRC_ARB]  = loss;
        sources[SRC_BYTE] = byte_done;
        sources[SRC_ADDR] = addr_hit;
        sources[SRC_NOACK]= noack;
        sources[SRC_IDLE] = went_idle && idle_irq_en;
    end

    status_flags #(.N_SRC(NUM_SRC)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .loss        (loss),
        .sources     (sources),
        .addr_hit    (addr_hit),
        .rw_bit      (rw_bit),
        .host_wr     (host_wr),
        .host_al_bit (host_al_bit),
        .host_if_bit (host_if_bit),
        .arb_lost    (arb_lost),
        .int_flag    (int_flag),
        .slave_rw    (slave_rw)
    );

    // Interrupt request gated by the enable
    always_comb irq = int_flag && irq_en;

    // Release the lines and drop master mode as soon as a loss shows
    always_comb begin
        bus_release = loss || arb_lost;
        master_keep = is_master && !bus_release;
    end

    // R11: no master keeps the bus in a cycle where a loss is present
    p_release_now_r11: assert property (@(posedge clk) disable iff (!rst_n)
        loss |-> (bus_release && !master_keep));

    // R9: with the enable low no request leaves the block
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R8: a bus-idle edge with its enable raises the flag next edge
    p_idle_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (went_idle && idle_irq_en) |=> int_flag);

endmodule

// File: tb/sim_i2c_arb_status.sv
// Bench for i2c_arb_status: a vector table walked by one loop, then directed
// tests for reset, write-one-to-clear, set priority, idle edge, irq and R/W.
module sim_i2c_arb_status;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bit_phase;
    logic       sda_strobe, sda_drv, sda_smp, is_master, is_tx;
    logic       start_req, rstart_req, stop_req, stop_seen, bus_busy;
    logic       byte_done, addr_hit, rw_bit;
    logic       host_wr, host_al_bit, host_if_bit, irq_en, idle_irq_en;
    logic       arb_lost, slave_rw, int_flag, irq, bus_release, master_keep;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    i2c_arb_status u0 (
        .clk(clk), .rst_n(rst_n), .bit_phase(bit_phase), .sda_strobe(sda_strobe),
        .sda_drv(sda_drv), .sda_smp(sda_smp), .is_master(is_master), .is_tx(is_tx),
        .start_req(start_req), .rstart_req(rstart_req), .stop_req(stop_req),
        .stop_seen(stop_seen), .bus_busy(bus_busy), .byte_done(byte_done),
        .addr_hit(addr_hit), .rw_bit(rw_bit), .host_wr(host_wr),
        .host_al_bit(host_al_bit), .host_if_bit(host_if_bit), .irq_en(irq_en),
        .idle_irq_en(idle_irq_en), .arb_lost(arb_lost), .slave_rw(slave_rw),
        .int_flag(int_flag), .irq(irq), .bus_release(bus_release),
        .master_keep(master_keep)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [1:0] ph;
        logic stb, drv, smp, ms, tx, sreq, rsreq, preq, pdet, busy, bdone, amatch;
        logic exp_al, exp_if;
    } vec_t;

    // req, ph, stb, drv, smp, ms, tx, sreq, rsreq, preq, pdet, busy, bdone, amatch, al, if
    localparam vec_t VECS [16] = '{
        '{1, 1, 1,1,0, 1,1, 0,0,0,0,0, 0,0, 1,1},  // R1 transmit-bit clash
        '{1, 1, 1,1,1, 1,1, 0,0,0,0,0, 0,0, 0,0},  // R1 wire agrees
        '{1, 1, 1,0,0, 1,1, 0,0,0,0,0, 0,0, 0,0},  // R1 master drives low
        '{1, 1, 0,1,0, 1,1, 0,0,0,0,0, 0,0, 0,0},  // R1 no strobe
        '{2, 2, 1,1,0, 1,0, 0,0,0,0,0, 0,0, 1,1},  // R2 receive-ack clash
        '{3, 0, 0,1,1, 1,1, 1,0,0,0,1, 0,0, 1,1},  // R3 START on busy bus
        '{3, 0, 0,1,1, 1,1, 1,0,0,0,0, 0,0, 0,0},  // R3 START on idle bus
        '{3, 0, 0,1,1, 0,0, 0,1,0,0,0, 0,0, 1,1},  // R3 repeated START as slave
        '{3, 0, 0,1,1, 1,1, 0,1,0,0,0, 0,0, 0,0},  // R3 repeated START as master
        '{4, 0, 0,1,1, 1,1, 0,0,0,1,0, 0,0, 1,1},  // R4 unrequested STOP
        '{4, 0, 0,1,1, 1,1, 0,0,1,1,0, 0,0, 0,0},  // R4 requested STOP
        '{4, 0, 0,1,1, 0,0, 0,0,0,1,0, 0,0, 0,0},  // R4 STOP seen as slave
        '{7, 0, 0,1,1, 0,0, 0,0,0,0,0, 1,0, 0,1},  // R7 byte done
        '{7, 0, 0,1,1, 0,0, 0,0,0,0,0, 0,1, 0,1},  // R7 address hit
        '{7, 3, 1,1,1, 1,1, 0,0,0,0,0, 0,0, 0,1},  // R7 missing ack, transmitting master
        '{7, 3, 1,1,1, 1,0, 0,0,0,0,0, 0,0, 0,0}   // R7 missing ack, receiving master
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bit_phase = 2'd0; sda_strobe = 0; sda_drv = 1; sda_smp = 1;
        is_master = 0; is_tx = 0; start_req = 0; rstart_req = 0; stop_req = 0;
        stop_seen = 0; bus_busy = 0; byte_done = 0; addr_hit = 0; rw_bit = 0;
        host_wr = 0; host_al_bit = 0; host_if_bit = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        idle_inputs();
        host_wr = 1; host_al_bit = 1; host_if_bit = 1;
        step();
        host_wr = 0; host_al_bit = 0; host_if_bit = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        idle_inputs();
        irq_en = 0; idle_irq_en = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R12 reset state
        chk("R12", "arb_lost",  arb_lost, 0);
        chk("R12", "int_flag",  int_flag, 0);
        chk("R12", "slave_rw",  slave_rw, 0);
        chk("R12", "irq",       irq,      0);

        // Table walk: R1..R4, R7, plus R11 combinational release
        for (int i = 0; i < 16; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d", v.req);
            bit_phase = v.ph; sda_strobe = v.stb; sda_drv = v.drv; sda_smp = v.smp;
            is_master = v.ms; is_tx = v.tx; start_req = v.sreq; rstart_req = v.rsreq;
            stop_req = v.preq; stop_seen = v.pdet; bus_busy = v.busy;
            byte_done = v.bdone; addr_hit = v.amatch;
            #1;
            chk("R11", $sformatf("bus_release row %0d", i), bus_release, v.exp_al);
            step();
            chk(tag, $sformatf("arb_lost row %0d", i), arb_lost, v.exp_al);
            chk(tag, $sformatf("int_flag row %0d", i), int_flag, v.exp_if);
            clear_all();
        end

        // R11 master kept with no loss, dropped in the same cycle as a loss
        is_master = 1; is_tx = 1; #1;
        chk("R11", "master_keep quiet", master_keep, 1);
        bit_phase = 2'd1; sda_strobe = 1; sda_smp = 0; #1;
        chk("R11", "master_keep on clash", master_keep, 0);
        step();
        sda_strobe = 0; sda_smp = 1; #1;
        chk("R11", "master_keep while flag set", master_keep, 0);
        chk("R11", "bus_release while flag set", bus_release, 1);

        // R5 writing zeros changes nothing, writing ones clears
        idle_inputs();
        host_wr = 1; step(); host_wr = 0;
        chk("R5", "arb_lost after zero write", arb_lost, 1);
        chk("R5", "int_flag after zero write", int_flag, 1);
        host_wr = 1; host_al_bit = 1; step(); idle_inputs();
        chk("R5", "arb_lost after one write", arb_lost, 0);
        chk("R5", "int_flag untouched by al write", int_flag, 1);
        host_wr = 1; host_if_bit = 1; step(); idle_inputs();
        chk("R5", "int_flag after one write", int_flag, 0);

        // R6 set and clear together: set wins
        start_req = 1; bus_busy = 1;
        host_wr = 1; host_al_bit = 1; host_if_bit = 1;
        step();
        chk("R6", "arb_lost set vs clear", arb_lost, 1);
        chk("R6", "int_flag set vs clear", int_flag, 1);
        clear_all();
        byte_done = 1; host_wr = 1; host_if_bit = 1; step(); idle_inputs();
        chk("R6", "int_flag byte vs clear", int_flag, 1);

        // R9 irq gating
        chk("R9", "irq with enable low", irq, 0);
        irq_en = 1; #1;
        chk("R9", "irq with enable high", irq, 1);
        clear_all();
        chk("R9", "irq after flag cleared", irq, 0);
        irq_en = 0;

        // R8 bus-idle edge, enable off then on
        bus_busy = 1; step();
        chk("R8", "rise sets nothing", int_flag, 0);
        bus_busy = 0; step();
        chk("R8", "fall with enable off", int_flag, 0);
        idle_irq_en = 1;
        bus_busy = 1; step();
        chk("R8", "rise with enable on", int_flag, 0);
        bus_busy = 0; step();
        chk("R8", "fall with enable on", int_flag, 1);
        idle_irq_en = 0;
        clear_all();

        // R10 slave read/write capture and hold
        addr_hit = 1; rw_bit = 1; step(); addr_hit = 0; rw_bit = 0;
        chk("R10", "slave_rw loads 1", slave_rw, 1);
        step();
        chk("R10", "slave_rw holds without match", slave_rw, 1);
        addr_hit = 1; rw_bit = 0; step(); addr_hit = 0;
        chk("R10", "slave_rw loads 0", slave_rw, 0);
        clear_all();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule